// File: doc/BRIEF.md
# Pseudo-Static RAM Access Controller

This block sits between a synchronous host and an asynchronous 1M x 16 pseudo-static RAM. The host side works one word at a time. It presents an address, a write flag, write data and two byte-lane enables together with a request. The controller accepts the request on a rising clock edge while `ready` is high. It then produces the chip-enable, write-enable, output-enable and lane-select waveforms, and owns the tristate enable of the shared data bus. Read data returns on `rd_data` with a one-cycle `rd_valid` strobe.

Every analog timing limit is held as a cycle count. Each count is computed from the clock period parameter by rounding up, with a floor of one cycle. After a read, the controller keeps the chip selected with its outputs on. If the next read stays inside the same aligned page of `PAGE_WORDS` words, it is served with the short in-page access time, and the low address bits may step in any order. The controller enforces the power-up hold-off and the ceiling on continuous chip-enable time. It also inserts the bus turnaround and deselect gaps that writes need.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, `mem_ce_n` stays high and `ready` stays low for at least ceil(150 us / clock period) cycles (30000 at 5 ns).
- R2: A read from the idle state holds chip enable and output enable low for ceil(70 ns / period) cycles (14) before the data is captured. `rd_valid` appears on the 15th cycle after the accepting edge.
- R3: A read whose address matches the previous read in bits [19:log2(PAGE_WORDS)], issued while the chip is still selected, is served in ceil(25 ns / period) cycles (5), so `rd_valid` arrives 6 cycles after acceptance and chip enable never rises in between.
- R4: An in-page burst may start at any word and visit the words of the page in any order, including descending, with correct data for each.
- R5: Chip enable is never low for more than ceil(8 us / period) consecutive cycles (1600). When the controller forces a deselect it keeps the chip deselected for at least 14 cycles, including when the host simply leaves the chip selected with no further requests.
- R6: During a write, `mem_we_n` is low for max(ceil(70 ns), ceil(45 ns)) cycles (14), `mem_oe_n` stays high and the bus is driven.
- R7: When a write ends, chip enable is already high on the cycle `mem_we_n` rises, giving at least one deselected cycle before the next access.
- R8: `req_be[0]` set means bits [7:0] are written (`mem_lb_n` low). `req_be[1]` set means bits [15:8] are written (`mem_ub_n` low). Lanes whose enable is clear keep their old contents. Reads select both lanes.
- R9: `mem_dq_oe` is high only while `mem_we_n` is low, and is low on the cycle before `mem_oe_n` falls. A write that follows a read first deselects for ceil(8 ns / period) cycles (2).
- R10: A read outside the current page while the chip is still selected ends the burst and takes the full 14-cycle access.
- R11: `mem_ce2` is always the complement of `mem_ce_n`.
- R12: A request is accepted on a rising edge where `req` and `ready` are both high. `rd_valid` is a single-cycle pulse carrying the word at the accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = low byte, bit 1 = high byte |
| ready | output | 1 | Controller can accept a request this cycle |
| rd_data | output | 16 | Captured read word |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| mem_addr | output | 20 | Address to the memory |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_ub_n | output | 1 | Active-low upper lane select |
| mem_lb_n | output | 1 | Active-low lower lane select |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tristate enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The interesting collision is a host request that arrives while the chip has been selected so long that the enable ceiling is reached. The controller must then choose between the page-hit fast path and the forced deselect in the same cycle. The bench provokes this by streaming several hundred in-page reads back to back, and separately by parking the controller in the selected state with no traffic. A bus model that returns a poison word unless the full or page access time has elapsed judges the outcome, together with a monitor that measures every low and high run of chip enable against the 1600- and 14-cycle limits.

// File: rtl/psram_pkg.sv
// Shared types and the nanosecond-to-cycle conversion for the PSRAM controller.
// Assumes all timing inputs are positive integers in nanoseconds.
package psram_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,   // power-up hold-off, chip deselected
        ST_IDLE,    // deselected, waiting for a request
        ST_READ,    // access running, CE and OE low
        ST_HOLD,    // chip left selected after a read (page open)
        ST_GAP,     // turnaround deselect before a write
        ST_WRITE,   // WE pulse
        ST_RECOV,   // deselect after a write
        ST_REST     // forced deselect after the enable ceiling
    } pc_state_t;

    // Round a time in ns up to whole clock cycles, never below one.
    function automatic int cyc_of(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/psram_timer.sv
// Down-counter that times each controller state.
// Loaded with N-1 on state entry; zero is high in the Nth cycle.
// Assumes load values fit in W bits.
module psram_timer #(
    parameter int W       = 15,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Count down toward zero, reload on request, preset during reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= W'(RST_VAL);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/psram_ce_guard.sv
// Measures how long chip enable has been continuously active.
// budget_ok drops once the run reaches LIMIT.
// Assumes LIMIT leaves room for one full access below the ceiling.
module psram_ce_guard #(
    parameter int W     = 11,
    parameter int LIMIT = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_active,
    output logic budget_ok
);
    logic [W-1:0] run;

    // Count active cycles, clear on any deselected cycle, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || !ce_active) run <= '0;
        else if (run != '1)       run <= run + 1'b1;
    end

    assign budget_ok = (run < W'(LIMIT));
endmodule

// File: rtl/psram_ctrl.sv
// Host-to-PSRAM access sequencer: power-up wait, random read/write,
// in-page reads with the chip held selected, enable-time ceiling.
// Assumes a 16-bit memory with two byte lanes and PAGE_WORDS of 4, 8 or 16.
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int CLK_PS     = 5000,
    parameter int AW         = 20,
    parameter int DW         = 16,
    parameter int PAGE_WORDS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_be,
    output logic          ready,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_ce2,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int T_RC  = cyc_of(70, CLK_PS);
    localparam int T_PC  = cyc_of(25, CLK_PS);
    localparam int T_WC  = cyc_of(70, CLK_PS);
    localparam int T_WP  = cyc_of(45, CLK_PS);
    localparam int T_WE  = (T_WC > T_WP) ? T_WC : T_WP;
    localparam int T_HZ  = cyc_of(8, CLK_PS);
    localparam int T_CPH = cyc_of(5, CLK_PS);
    localparam int T_PU  = cyc_of(150000, CLK_PS);
    localparam int T_CEM = cyc_of(8000, CLK_PS);
    localparam int PB    = $clog2(PAGE_WORDS);
    localparam int TW    = $clog2(T_PU + 1);
    localparam int GW    = $clog2(T_CEM + 1);
    localparam int CE_BUDGET = T_CEM - T_RC - 4;

    pc_state_t     st, st_nxt;
    logic          tmr_load, tmr_zero, budget_ok, accept, same_page;
    logic          ce_active, oe_active;
    logic [TW-1:0] tmr_val;
    logic [1:0]    be_q;

    psram_timer #(.W(TW), .RST_VAL(T_PU - 1)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .zero(tmr_zero)
    );

    psram_ce_guard #(.W(GW), .LIMIT(CE_BUDGET)) u_guard (
        .clk(clk), .rst_n(rst_n), .ce_active(ce_active), .budget_ok(budget_ok)
    );

    assign ready     = (st == ST_IDLE) || (st == ST_HOLD && budget_ok);
    assign accept    = req && ready;
    assign same_page = (req_addr[AW-1:PB] == mem_addr[AW-1:PB]);

    // Next-state selection and timer reload for the entered state.
    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st)
            ST_PWRUP: if (tmr_zero) st_nxt = ST_IDLE;
            ST_IDLE: if (accept) begin
                tmr_load = 1'b1;
                if (req_we) begin st_nxt = ST_WRITE; tmr_val = TW'(T_WE - 1); end
                else        begin st_nxt = ST_READ;  tmr_val = TW'(T_RC - 1); end
            end
            ST_READ: if (tmr_zero) st_nxt = ST_HOLD;
            ST_HOLD: begin
                if (!budget_ok) begin
                    st_nxt = ST_REST; tmr_load = 1'b1; tmr_val = TW'(T_RC - 1);
                end else if (accept) begin
                    tmr_load = 1'b1;
                    if (req_we)         begin st_nxt = ST_GAP;  tmr_val = TW'(T_HZ - 1); end
                    else if (same_page) begin st_nxt = ST_READ; tmr_val = TW'(T_PC - 1); end
                    else                begin st_nxt = ST_READ; tmr_val = TW'(T_RC - 1); end
                end
            end
            ST_GAP: if (tmr_zero) begin
                st_nxt = ST_WRITE; tmr_load = 1'b1; tmr_val = TW'(T_WE - 1);
            end
            ST_WRITE: if (tmr_zero) begin
                st_nxt = ST_RECOV; tmr_load = 1'b1; tmr_val = TW'(T_CPH - 1);
            end
            ST_RECOV, ST_REST: if (tmr_zero) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_PWRUP;
        else        st <= st_nxt;
    end

    // Latch the accepted request's address, data and lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            be_q       <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            be_q       <= req_be;
        end
    end

    // Capture read data as the access count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (st == ST_READ) && tmr_zero;
            if ((st == ST_READ) && tmr_zero) rd_data <= mem_dq_in;
        end
    end

    assign ce_active = (st == ST_READ) || (st == ST_HOLD) || (st == ST_WRITE);
    assign oe_active = (st == ST_READ) || (st == ST_HOLD);
    assign mem_ce_n  = !ce_active;
    assign mem_ce2   = ce_active;
    assign mem_oe_n  = !oe_active;
    assign mem_we_n  = (st != ST_WRITE);
    assign mem_dq_oe = (st == ST_WRITE);
    assign mem_lb_n  = !(oe_active || (st == ST_WRITE && be_q[0]));
    assign mem_ub_n  = !(oe_active || (st == ST_WRITE && be_q[1]));
endmodule

// File: rtl/psram_ctrl_chk.sv
// Timing checker bound to psram_ctrl: watches the memory-side pins.
// Assumes the same clock period parameter as the controller.
module psram_ctrl_chk
    import psram_pkg::*;
#(
    parameter int CLK_PS = 5000
) (
    input logic clk,
    input logic rst_n,
    input logic ready,
    input logic mem_ce_n,
    input logic mem_we_n,
    input logic mem_oe_n,
    input logic mem_dq_oe
);
    localparam int C_PU  = cyc_of(150000, CLK_PS);
    localparam int C_CEM = cyc_of(8000, CLK_PS);
    localparam int C_WP  = cyc_of(45, CLK_PS);

    int unsigned up_cnt, ce_run, we_run;

    // Cycles since reset, saturating past the hold-off.
    always_ff @(posedge clk) begin
        if (!rst_n)                         up_cnt <= 0;
        else if (up_cnt < C_PU + 1)         up_cnt <= up_cnt + 1;
    end

    // Lengths of the current chip-enable and write-enable low runs.
    always_ff @(posedge clk) begin
        if (!rst_n || mem_ce_n) ce_run <= 0;
        else                    ce_run <= ce_run + 1;
        if (!rst_n || mem_we_n) we_run <= 0;
        else                    we_run <= we_run + 1;
    end

    AST_PWRUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt < C_PU - 1) |-> (mem_ce_n && !ready));                 // R1
    AST_CE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        ce_run < C_CEM);                                                // R5
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run >= C_WP));                          // R6
    AST_WE_MASKS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe));                         // R6
    AST_BUS_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);                                       // R9
    AST_BUS_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));                         // R9
    AST_WRITE_END_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_ce_n);                                  // R7
endmodule

bind psram_ctrl psram_ctrl_chk #(.CLK_PS(CLK_PS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_psram_ctrl.sv
// Bench: PSRAM pin model with access-time poisoning, host driver,
// random and directed traffic, pin-timing monitors.
module sim_psram_ctrl;
    localparam int CLK_PS = 5000;
    localparam int B_RC   = (70000 + CLK_PS - 1) / CLK_PS;     // 14
    localparam int B_PC   = (25000 + CLK_PS - 1) / CLK_PS;     // 5
    localparam int B_PU   = (150000000 + CLK_PS - 1) / CLK_PS; // 30000
    localparam int B_CEM  = (8000000 + CLK_PS - 1) / CLK_PS;   // 1600
    localparam int B_WE   = 14;
    localparam logic [15:0] POISON = 16'hBAD0;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ready, rd_valid, ce_n, ce2, we_n, oe_n, ub_n, lb_n, dq_oe;
    logic [15:0] rd_data, dq_out, dq_in;
    logic [19:0] maddr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2500ps clk = ~clk;

    psram_ctrl #(.CLK_PS(CLK_PS)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .ready(ready), .rd_data(rd_data),
        .rd_valid(rd_valid), .mem_addr(maddr), .mem_ce_n(ce_n), .mem_ce2(ce2),
        .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_ub_n(ub_n), .mem_lb_n(lb_n),
        .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---- memory model (512 words: bit 19 and bits 7:0) ----
    logic [15:0] cmem [512];
    logic [15:0] emem [512];
    function automatic int idx(input logic [19:0] a);
        return {a[19], a[7:0]};
    endfunction
    function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] d,
                                          input logic [1:0] be);
        return {be[1] ? d[15:8] : o[15:8], be[0] ? d[7:0] : o[7:0]};
    endfunction

    int rc = 0, pc = 0;
    logic [19:0] prev_a = '0;
    bit prev_act = 0;
    always_comb begin
        if (!ce_n && !oe_n && we_n)
            dq_in = (rc >= B_RC && pc >= B_PC) ? cmem[idx(maddr)] : POISON;
        else
            dq_in = 16'h0000;
    end

    // ---- pin monitors at the falling edge ----
    int ce_lo = 0, ce_hi = 0, last_lo = 0, we_lo = 0, rest_seen = 0;
    bit prev_we_lo = 0, prev_dq_oe = 0, prev_oe_n = 1, prev_ce_n = 1, oe_bad = 0;
    logic [19:0] wl_a; logic [15:0] wl_d; logic wl_ub, wl_lb;
    logic [1:0] cur_be = 2'b11;
    bit mon_on = 0;

    always @(negedge clk) if (mon_on) begin
        // access-time counters of the chip model
        if (ce_n || oe_n || !we_n) begin rc = 0; pc = 0; end
        else if (!prev_act || maddr[19:4] != prev_a[19:4]) begin rc = 1; pc = 1; end
        else if (maddr != prev_a) begin rc++; pc = 1; end
        else begin rc++; pc++; end
        prev_act = !ce_n && !oe_n && we_n;
        prev_a   = maddr;
        // write capture and commit
        if (!we_n) begin
            if (!oe_n) oe_bad = 1;
            wl_a = maddr; wl_d = dq_out; wl_ub = ub_n; wl_lb = lb_n; we_lo++;
            if (!ce_n && (wl_ub != !cur_be[1] || wl_lb != !cur_be[0]))
                chk(0, "R8 lane selects", {wl_ub, wl_lb}, {!cur_be[1], !cur_be[0]});
        end else if (prev_we_lo) begin
            chk(we_lo >= B_WE && !oe_bad, "R6 WE width/OE high", we_lo, B_WE);
            chk(ce_n, "R7 deselected at write end", ce_n, 1);
            cmem[idx(wl_a)] = merge(cmem[idx(wl_a)], wl_d, {!wl_ub, !wl_lb});
            we_lo = 0; oe_bad = 0;
        end
        prev_we_lo = !we_n;
        // bus ownership
        if (dq_oe && we_n) chk(0, "R9 bus driven outside write", dq_oe, 0);
        if (prev_oe_n && !oe_n) chk(!prev_dq_oe, "R9 turnaround before OE", prev_dq_oe, 0);
        prev_oe_n = oe_n; prev_dq_oe = dq_oe;
        if (ce2 != !ce_n) chk(0, "R11 enable pair", ce2, !ce_n);
        // chip-enable run lengths
        if (!ce_n) begin
            if (prev_ce_n) begin
                chk(ce2 == 1'b1, "R11 enable pair at select", ce2, 1);
                if (last_lo > 1000) begin
                    chk(ce_hi >= B_RC, "R5 forced deselect length", ce_hi, B_RC);
                    rest_seen++;
                end
                ce_lo = 0;
            end
            ce_lo++;
        end else begin
            if (!prev_ce_n) begin
                chk(ce_lo <= B_CEM, "R5 enable run ceiling", ce_lo, B_CEM);
                last_lo = ce_lo; ce_hi = 0;
            end
            ce_hi++;
        end
        prev_ce_n = ce_n;
    end

    // ---- host driver ----
    task automatic issue(input logic we, input logic [19:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        req = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        while (!ready) @(negedge clk);
        if (we) cur_be = be;
        @(negedge clk);
        req = 0;
    endtask

    task automatic wr(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
        emem[idx(a)] = merge(emem[idx(a)], d, be);
        issue(1'b1, a, d, be);
    endtask

    task automatic rd(input logic [19:0] a, input string tag, output int lat);
        issue(1'b0, a, 16'h0, 2'b11);
        lat = 1;
        while (!rd_valid) begin @(negedge clk); lat++; end
        chk(rd_data == emem[idx(a)], tag, rd_data, emem[idx(a)]);
        @(negedge clk);
        chk(!rd_valid, "R12 valid is one cycle", rd_valid, 0);
    endtask

    initial begin
        int lat, wait_cyc;
        bit early;
        void'($urandom(32'd1234));
        for (int i = 0; i < 512; i++) begin cmem[i] = '0; emem[i] = '0; end
        repeat (4) @(negedge clk);
        chk(!ready && ce_n && !ce2 && !dq_oe && !rd_valid, "R1 reset state",
            {ready, ce_n, ce2, dq_oe}, 4'b0100);
        rst_n = 1; mon_on = 1;
        // R1: power-up hold-off
        wait_cyc = 0; early = 0;
        while (!ready) begin
            @(negedge clk); wait_cyc++;
            if (!ce_n) early = 1;
        end
        chk(wait_cyc >= B_PU - 2 && !early, "R1 power-up hold-off", wait_cyc, B_PU);

        // R8: lane writes and read-back
        wr(20'h00010, 16'hA1B2, 2'b11);
        wr(20'h00010, 16'hFFCC, 2'b01);
        rd(20'h00010, "R8 low lane only", lat);
        chk(lat == B_RC + 1, "R2 random read latency", lat, B_RC + 1);
        wr(20'h00011, 16'h1234, 2'b11);
        wr(20'h00011, 16'h77EE, 2'b10);
        rd(20'h00011, "R8 high lane only", lat);
        chk(lat == B_RC + 1, "R2 read after write latency", lat, B_RC + 1);

        // R3/R4: page burst, descending order, then R10 out of page
        for (int k = 0; k < 16; k++) wr(20'h00020 + 20'(k), 16'(16'h5A00 + k * 3), 2'b11);
        rd(20'h00027, "R4 burst start mid-page", lat);
        for (int k = 15; k >= 0; k--) begin
            rd(20'h00020 + 20'(k), "R4 descending in-page data", lat);
            chk(lat == B_PC + 1, "R3 in-page latency", lat, B_PC + 1);
        end
        rd(20'h00013, "R10 out-of-page data", lat);
        chk(lat == B_RC + 1, "R10 out-of-page latency", lat, B_RC + 1);
        rd(20'h80013, "R10 far page data", lat);
        chk(lat == B_RC + 1, "R10 far page latency", lat, B_RC + 1);

        // R5: long burst must hit the enable ceiling and still return good data
        for (int k = 0; k < 320; k++)
            rd(20'h00020 + 20'(k % 16), "R5 data across forced deselect", lat);
        chk(rest_seen >= 1, "R5 forced deselect during burst", rest_seen, 1);
        // R5: idle with chip held selected
        rd(20'h00040, "R5 park read", lat);
        repeat (B_CEM + 40) @(negedge clk);
        chk(ce_n, "R5 parked chip released", ce_n, 1);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [19:0] a;
            a = {1'($urandom_range(0, 1)), 11'h000, 8'($urandom_range(0, 63))};
            if ($urandom_range(0, 2) == 0)
                wr(a, 16'($urandom), 2'($urandom_range(1, 3)));
            else
                rd(a, "R2 random traffic data", lat);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule